// File: doc/BRIEF.md
# Phase-Shifted Full-Bridge Gate Timing Generator

This block turns two timing events into the six digital gate commands of a zero-voltage-switched, phase-shifted full bridge with a current-doubler synchronous rectifier. A cycle-boundary pulse from an external oscillator flips the passive leg. The first phase-modulator trip after each boundary flips the active leg. The power delivered depends on how long the two diagonal pairs overlap, not on the width of any single pulse. If no trip arrives in a cycle, the active leg is flipped at the next boundary, which gives the longest possible overlap.

Each leg has its own programmable dead time, counted in clock cycles. Both switches of a leg stay off for that time before the incoming switch turns on. The dead-time counts are captured only on a boundary pulse. The two rectifier commands follow the bridge targets: one rectifier per power half-cycle, and both during freewheeling. Deasserting the enable clears every output and the internal toggle, so a restart always begins in the same state.

Top module: `pfb_gate_timer`

## Requirements
- R1: After reset, or while enable is low, all six outputs are 0. On the first clock edge that samples enable high, passive low, active low and both rectifier outputs go to 1, and both high-side outputs stay 0.
- R2: Every boundary pulse sampled while enabled flips the passive leg's target. The outgoing passive switch turns off on the next edge.
- R3: Only the first trip after a boundary flips the active leg. Further trips in the same cycle, and trips after enable but before the first boundary, leave the active outputs unchanged.
- R4: If no trip was taken since the previous boundary, the next boundary flips the active leg together with the passive leg.
- R5: The high and low outputs of one leg are never 1 in the same cycle.
- R6: After a leg's target changes, both of its outputs are 0 for max(N,1) cycles, where N is that leg's latched dead-time count. The incoming output then turns on.
- R7: The dead-time counts are latched only on a boundary pulse. A change between boundaries does not affect transitions until the next boundary.
- R8: Rectifier E alone is 1 while the passive target is high and the active target is low. Rectifier F alone is 1 in the opposite case. Both are 1 when the two targets are equal. The rectifier outputs change on the same edge that samples the boundary or trip.
- R9: A clock edge that samples enable low drives all six outputs to 0 and resets the toggle. After restart, the first boundary selects rectifier E.
- R10: A trip in the same cycle as a boundary is not taken: only the boundary action occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| en | input | 1 | Run enable; low forces all outputs off |
| cyc_start | input | 1 | Oscillator cycle-boundary pulse |
| trip | input | 1 | Phase-modulator trip pulse |
| pas_dead | input | DW | Passive-leg dead time in cycles |
| act_dead | input | DW | Active-leg dead time in cycles |
| pas_hi | output | 1 | Passive-leg high-side command |
| pas_lo | output | 1 | Passive-leg low-side command |
| act_hi | output | 1 | Active-leg high-side command |
| act_lo | output | 1 | Active-leg low-side command |
| rect_e | output | 1 | Rectifier E command |
| rect_f | output | 1 | Rectifier F command |

## Verification
The rectifier outputs change on the edge that samples a boundary or trip. A leg's outgoing switch drops one edge later, and its incoming switch rises max(N,1) edges after that. Enable low clears every output on the first edge that samples it. The bench drives each input just after a rising edge and compares the full six-bit output vector after every following edge. Every step of each transition window is therefore checked in the exact cycle it is due, and never only once the outputs have settled.

// File: rtl/pfb_pkg.sv
package pfb_pkg;

    typedef struct packed {
        logic run;
        logic pas_tgt;
        logic act_tgt;
        logic act_done;
        logic rect_e;
        logic rect_f;
    } seq_st_t;

    typedef struct packed {
        logic side;
        logic hi;
        logic lo;
    } leg_st_t;

    localparam int NUM_LEGS = 2;
    localparam int LEG_PAS  = 0;
    localparam int LEG_ACT  = 1;

endpackage

// File: rtl/pfb_seq.sv
module pfb_seq
    import pfb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cyc_start,
    input  logic          trip,
    input  logic [DW-1:0] pas_dead,
    input  logic [DW-1:0] act_dead,
    output logic          pas_tgt,
    output logic          act_tgt,
    output logic [DW-1:0] pas_len,
    output logic [DW-1:0] act_len,
    output logic          rect_e,
    output logic          rect_f
);

    localparam seq_st_t SEQ_IDLE = '{run: 1'b0, pas_tgt: 1'b0, act_tgt: 1'b0,
                                     act_done: 1'b1, rect_e: 1'b0, rect_f: 1'b0};

    seq_st_t       s_d, s_q;
    logic [DW-1:0] pl_d, pl_q, al_d, al_q;
    logic          power;

    always_comb begin
        s_d   = s_q;
        pl_d  = pl_q;
        al_d  = al_q;
        power = 1'b0;
        if (!en) begin
            s_d = SEQ_IDLE;
        end else begin
            s_d.run = 1'b1;
            if (cyc_start) begin
                s_d.pas_tgt = ~s_q.pas_tgt;
                if (!s_q.act_done) begin
                    s_d.act_tgt = ~s_q.act_tgt;
                end
                s_d.act_done = 1'b0;
                pl_d = pas_dead;
                al_d = act_dead;
            end else if (trip && !s_q.act_done) begin
                s_d.act_tgt  = ~s_q.act_tgt;
                s_d.act_done = 1'b1;
            end
            power      = s_d.pas_tgt ^ s_d.act_tgt;
            s_d.rect_e = !power || s_d.pas_tgt;
            s_d.rect_f = !power || !s_d.pas_tgt;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q  <= SEQ_IDLE;
            pl_q <= '0;
            al_q <= '0;
        end else begin
            s_q  <= s_d;
            pl_q <= pl_d;
            al_q <= al_d;
        end
    end

    assign pas_tgt = s_q.pas_tgt;
    assign act_tgt = s_q.act_tgt;
    assign pas_len = pl_q;
    assign act_len = al_q;
    assign rect_e  = s_q.rect_e;
    assign rect_f  = s_q.rect_f;

    // R8
    rect_never_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.run |-> (s_q.rect_e || s_q.rect_f));

    // R3
    extra_trip_ignored_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && trip && !cyc_start && s_q.act_done) |=> $stable(s_q.act_tgt));

    // R4
    missed_trip_flip_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_start && !s_q.act_done) |=> (s_q.act_tgt != $past(s_q.act_tgt)));

    // R7
    len_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(en && cyc_start) |=> ($stable(pl_q) && $stable(al_q)));

endmodule

// File: rtl/pfb_leg.sv
module pfb_leg
    import pfb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          tgt,
    input  logic [DW-1:0] dead_len,
    output logic          hi,
    output logic          lo
);

    localparam logic [DW-1:0] ONE = DW'(1);

    leg_st_t       l_d, l_q;
    logic [DW-1:0] cnt_d, cnt_q;

    always_comb begin
        l_d   = l_q;
        cnt_d = cnt_q;
        if (!en) begin
            l_d   = '0;
            cnt_d = '0;
        end else if (tgt != l_q.side) begin
            l_d.side = tgt;
            l_d.hi   = 1'b0;
            l_d.lo   = 1'b0;
            cnt_d    = dead_len;
        end else if (cnt_q > ONE) begin
            cnt_d  = cnt_q - ONE;
            l_d.hi = 1'b0;
            l_d.lo = 1'b0;
        end else begin
            cnt_d  = '0;
            l_d.hi = l_q.side;
            l_d.lo = ~l_q.side;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            l_q   <= '0;
            cnt_q <= '0;
        end else begin
            l_q   <= l_d;
            cnt_q <= cnt_d;
        end
    end

    assign hi = l_q.hi;
    assign lo = l_q.lo;

    // R5
    leg_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(l_q.hi && l_q.lo));

    // R6
    hi_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_q.hi) |-> !$past(l_q.lo));

    // R6
    lo_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(l_q.lo) |-> !$past(l_q.hi));

endmodule

// File: rtl/pfb_gate_timer.sv
module pfb_gate_timer
    import pfb_pkg::*;
#(
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          en,
    input  logic          cyc_start,
    input  logic          trip,
    input  logic [DW-1:0] pas_dead,
    input  logic [DW-1:0] act_dead,
    output logic          pas_hi,
    output logic          pas_lo,
    output logic          act_hi,
    output logic          act_lo,
    output logic          rect_e,
    output logic          rect_f
);

    logic [NUM_LEGS-1:0]         tgt_w;
    logic [NUM_LEGS-1:0][DW-1:0] len_w;
    logic [NUM_LEGS-1:0]         hi_w, lo_w;

    pfb_seq #(.DW(DW)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .en        (en),
        .cyc_start (cyc_start),
        .trip      (trip),
        .pas_dead  (pas_dead),
        .act_dead  (act_dead),
        .pas_tgt   (tgt_w[LEG_PAS]),
        .act_tgt   (tgt_w[LEG_ACT]),
        .pas_len   (len_w[LEG_PAS]),
        .act_len   (len_w[LEG_ACT]),
        .rect_e    (rect_e),
        .rect_f    (rect_f)
    );

    for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
        pfb_leg #(.DW(DW)) u_leg (
            .clk      (clk),
            .rst_n    (rst_n),
            .en       (en),
            .tgt      (tgt_w[g]),
            .dead_len (len_w[g]),
            .hi       (hi_w[g]),
            .lo       (lo_w[g])
        );
    end

    assign pas_hi = hi_w[LEG_PAS];
    assign pas_lo = lo_w[LEG_PAS];
    assign act_hi = hi_w[LEG_ACT];
    assign act_lo = lo_w[LEG_ACT];

    // R9
    disable_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> !(pas_hi || pas_lo || act_hi || act_lo || rect_e || rect_f));

    // R2
    pas_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (en && cyc_start && $past(en)) |=> ##1 !(pas_hi || pas_lo));

endmodule

// File: tb/sim_pfb_gate_timer.sv
module sim_pfb_gate_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       en = 1'b0;
    logic       cyc_start = 1'b0;
    logic       trip = 1'b0;
    logic [7:0] pas_dead = '0;
    logic [7:0] act_dead = '0;
    logic       pas_hi, pas_lo, act_hi, act_lo, rect_e, rect_f;

    int  n_tests = 0;
    int  n_fail  = 0;
    int  overlap_seen = 0;
    bit  done = 1'b0;

    always #5 clk = ~clk;

    pfb_gate_timer #(.DW(8)) u0 (
        .clk, .rst_n, .en, .cyc_start, .trip, .pas_dead, .act_dead,
        .pas_hi, .pas_lo, .act_hi, .act_lo, .rect_e, .rect_f
    );

    // bit order: pas_hi pas_lo act_hi act_lo rect_e rect_f
    function automatic logic [5:0] outs();
        return {pas_hi, pas_lo, act_hi, act_lo, rect_e, rect_f};
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [5:0] exp);
        n_tests++;
        if (outs() !== exp) begin
            n_fail++;
            $display("FAIL %s: outputs %b expected %b at %0t", req, outs(), exp, $time);
        end
    endtask

    task automatic boundary();
        cyc_start = 1'b1;
        tick();
        cyc_start = 1'b0;
    endtask

    task automatic trip_pulse();
        trip = 1'b1;
        tick();
        trip = 1'b0;
    endtask

    always @(negedge clk) begin
        if (rst_n && ((pas_hi && pas_lo) || (act_hi && act_lo))) overlap_seen++;
    end

    task automatic t_reset_enable();
        chk("R1 reset", 6'b000000);
        tick();
        rst_n = 1'b1;
        tick();
        chk("R1 disabled", 6'b000000);
        en = 1'b1;
        tick();
        chk("R1 first enable", 6'b010111);
        trip_pulse();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 trip before boundary", 6'b010111);
        end
    endtask

    task automatic t_passive();
        pas_dead = 8'd3;
        act_dead = 8'd2;
        boundary();
        chk("R8 E only", 6'b010110);
        tick();
        chk("R2 passive off", 6'b000110);
        tick();
        chk("R6 dead 1", 6'b000110);
        tick();
        chk("R6 dead 2", 6'b000110);
        tick();
        chk("R6 passive hi on", 6'b100110);
    endtask

    task automatic t_active();
        trip_pulse();
        chk("R8 freewheel", 6'b100111);
        tick();
        chk("R3 active off", 6'b100011);
        tick();
        chk("R6 active dead", 6'b100011);
        tick();
        chk("R3 active hi on", 6'b101011);
        trip_pulse();
        for (int i = 0; i < 3; i++) begin
            tick();
            chk("R3 second trip ignored", 6'b101011);
        end
    endtask

    task automatic t_missed_trip();
        boundary();
        chk("R8 F only", 6'b101001);
        tick();
        chk("R2 passive hi off", 6'b001001);
        tick();
        tick();
        chk("R6 passive dead", 6'b001001);
        tick();
        chk("R2 passive lo on", 6'b011001);
        boundary();
        chk("R4 E only at boundary", 6'b011010);
        tick();
        chk("R4 both legs off", 6'b000010);
        tick();
        chk("R4 dead", 6'b000010);
        tick();
        chk("R4 active lo on", 6'b000110);
        tick();
        chk("R4 passive hi on", 6'b100110);
    endtask

    task automatic t_sampling();
        act_dead = 8'd5;
        pas_dead = 8'd1;
        tick();
        trip_pulse();
        chk("R7 freewheel", 6'b100111);
        tick();
        tick();
        chk("R7 old dead", 6'b100011);
        tick();
        chk("R7 old active dead used", 6'b101011);
        boundary();
        chk("R7 F only", 6'b101001);
        tick();
        chk("R7 passive off", 6'b001001);
        tick();
        chk("R7 new passive dead used", 6'b011001);
        trip_pulse();
        chk("R8 freewheel lo", 6'b011011);
        tick();
        chk("R7 active off", 6'b010011);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R7 new active dead", 6'b010011);
        end
        tick();
        chk("R7 active lo on", 6'b010111);
    endtask

    task automatic t_coincident();
        cyc_start = 1'b1;
        trip = 1'b1;
        tick();
        cyc_start = 1'b0;
        trip = 1'b0;
        chk("R10 boundary only", 6'b010110);
        tick();
        chk("R10 passive off", 6'b000110);
        for (int i = 0; i < 4; i++) begin
            tick();
            chk("R10 active held", 6'b100110);
        end
        trip_pulse();
        chk("R10 later trip taken", 6'b100111);
    endtask

    task automatic t_disable();
        en = 1'b0;
        tick();
        chk("R9 off", 6'b000000);
        tick();
        chk("R9 stays off", 6'b000000);
        en = 1'b1;
        tick();
        chk("R9 restart", 6'b010111);
        boundary();
        chk("R9 first pair E", 6'b010110);
    endtask

    initial begin
        #1;
        t_reset_enable();
        t_passive();
        t_active();
        t_missed_trip();
        t_sampling();
        t_coincident();
        t_disable();
        n_tests++;
        if (overlap_seen != 0) begin
            n_fail++;
            $display("FAIL R5: %0d overlap cycles expected 0", overlap_seen);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: run did not end, expected completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule